// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block brings the contacts of an inserted smart card up and down in a fixed order. All of its timing comes from a slow step tick, one step being `TICK_DIV` system clocks. A host asks for a card session by pulling its active-low start request down. The block accepts the request only on a falling edge of that line, and only while a card is present, the supply alarm is clear and no overcurrent is flagged. It then turns on the step-up converter and enables card supply, which also releases the low-impedance clamp. Next it enables the I/O buffer and opens a short window in which the host's reset-in line gates the card clock, so that the host can count clock pulses during the answer-to-reset. Finally it hands the card reset contact over to the inverse of reset-in, with the clock running freely.

Raising the start request shuts the card down in the reverse order. A card removal, a supply alarm or an overcurrent does the same as an emergency, and pulls the active-low fault line down. These three inputs pass through a two-flop synchronizer. The fault line is released once the shutdown is complete. After a card removal it stays low until a card is seen again. The analog supply ramp and the converter itself sit outside this block, which only drives their enables.

Top module: `card_power_sequencer`

## Requirements
- R1: Out of reset and whenever idle: conv_en, vcc_en, io_en, card_clk and card_rst are 0, clamp_en is 1 and fault_n is 1. Whenever clamp_en is 1, vcc_en, io_en, card_clk and card_rst are all 0.
- R2: A session starts only on a 1-to-0 transition of start_n seen while idle with card_present=1, supply_alarm=0 and overcurrent=0. Holding start_n at 0 while these conditions become true does not start a session.
- R3: conv_en goes to 1 on the clock edge that accepts the start (step 0). vcc_en goes to 1 and clamp_en goes to 0 after 2 ticks, that is 2*TICK_DIV cycles later.
- R4: io_en goes to 1 after 4 ticks, and never while vcc_en is 0.
- R5: From tick 4 up to tick 7, card_clk equals clk_src AND rst_in and card_rst stays 0. Before tick 4, card_clk is 0 whatever rst_in is.
- R6: From tick 7 on, card_clk equals clk_src regardless of rst_in, and card_rst equals NOT rst_in.
- R7: A 0-to-1 transition of start_n while active forces card_rst to 0 at the next edge. card_clk stops and io_en clears 1 tick later. vcc_en clears 2 ticks later. conv_en clears and clamp_en sets 5 ticks later.
- R8: A change of card_present to 0, or of supply_alarm or overcurrent to 1, during a session drives fault_n to 0 and starts the shutdown of R7 on the third clock edge after the input change.
- R9: After an emergency shutdown, fault_n returns to 1 on the edge that reaches idle, unless the cause was card removal. In that case fault_n stays 0 until card_present is 1 again, and rises on the third edge after insertion.
- R10: A fault during power-up goes straight to shutdown. Outputs not yet enabled (for example vcc_en before tick 2) stay 0 throughout the shutdown.
- R11: A falling start_n during a shutdown is ignored. The block stays idle after the shutdown ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_n | input | 1 | host session request, active low |
| card_present | input | 1 | raw card-present detect, active high |
| supply_alarm | input | 1 | raw supply-too-low alarm, active high |
| overcurrent | input | 1 | raw card supply fault, active high |
| rst_in | input | 1 | host reset-in; gates the clock in the window, then drives card reset inverted |
| clk_src | input | 1 | selected card clock source |
| conv_en | output | 1 | step-up converter enable |
| vcc_en | output | 1 | card supply enable |
| clamp_en | output | 1 | low-impedance clamp of contacts to ground |
| io_en | output | 1 | card I/O buffer enable |
| card_clk | output | 1 | clock to the card contact |
| card_rst | output | 1 | reset to the card contact |
| fault_n | output | 1 | fault report, active low |

## Verification
The bench uses TICK_DIV=4. Every contact edge is due at an exact edge count from the edge that changes state: the start-accept edge for power-up, the start_n rise for shutdown, or the third edge after a raw fault or insertion, which covers the two synchronizer flops. Each check samples at the falling clock edge just before the due edge and again just after it, so an early or late change by a single cycle shows up. The clock and reset paths through the window are combinational from rst_in and clk_src, so the bench changes those inputs in mid-cycle and samples 1 ns later.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_UP    = 2'd1,
        ST_ON    = 2'd2,
        ST_DOWN  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/cardseq_sync.sv
module cardseq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stg
            logic [W-1:0] flop_q;
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) flop_q <= '0;
                    else        flop_q <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) flop_q <= '0;
                    else        flop_q <= g_stg[i-1].flop_q;
                end
            end
        end
    endgenerate

    assign q = g_stg[STAGES-1].flop_q;
endmodule

// File: rtl/cardseq_tick.sv
module cardseq_tick #(
    parameter int TICK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        if (restart || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cardseq_fsm.sv
module cardseq_fsm
    import cardseq_pkg::*;
#(
    parameter int VCC_STEP    = 2,
    parameter int IO_STEP     = 4,
    parameter int RST_STEP    = 7,
    parameter int CLKOFF_STEP = 1,
    parameter int IOOFF_STEP  = 1,
    parameter int VCCOFF_STEP = 2,
    parameter int OFF_STEP    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_n,
    input  logic present_s,
    input  logic alarm_s,
    input  logic ovc_s,
    input  logic rst_in,
    input  logic clk_src,
    output logic restart,
    output logic conv_en,
    output logic vcc_en,
    output logic clamp_en,
    output logic io_en,
    output logic card_clk,
    output logic card_rst,
    output logic fault_n
);
    localparam int MAXS = (OFF_STEP > RST_STEP) ? OFF_STEP : RST_STEP;
    localparam int SW   = $clog2(MAXS + 1);
    localparam logic [SW-1:0] K_VCC    = SW'(VCC_STEP);
    localparam logic [SW-1:0] K_IO     = SW'(IO_STEP);
    localparam logic [SW-1:0] K_ONM1   = SW'(RST_STEP - 1);
    localparam logic [SW-1:0] K_CLKOFF = SW'(CLKOFF_STEP);
    localparam logic [SW-1:0] K_IOOFF  = SW'(IOOFF_STEP);
    localparam logic [SW-1:0] K_VCCOFF = SW'(VCCOFF_STEP);
    localparam logic [SW-1:0] K_OFFM1  = SW'(OFF_STEP - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [SW-1:0] step;
        logic          start_prev;
        logic          fault_n;
        logic          removed;
        logic          vcc_on;
        logic          io_on;
        logic          clk_on;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_IDLE, step: '0, start_prev: 1'b1,
                                 fault_n: 1'b1, removed: 1'b0, vcc_on: 1'b0,
                                 io_on: 1'b0, clk_on: 1'b0};

    seq_t cur_q, nxt_d;
    logic fault_now, go_down;

    assign fault_now = !present_s || alarm_s || ovc_s;
    assign go_down   = fault_now || start_n;

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.start_prev = start_n;
        unique case (cur_q.state)
            ST_IDLE: begin
                nxt_d.step = '0;
                if (cur_q.removed && present_s) begin
                    nxt_d.removed = 1'b0;
                    nxt_d.fault_n = 1'b1;
                end
                if (cur_q.start_prev && !start_n && !fault_now) begin
                    nxt_d.state = ST_UP;
                end
            end
            ST_UP: begin
                if (go_down) begin
                    nxt_d.state  = ST_DOWN;
                    nxt_d.step   = '0;
                    nxt_d.vcc_on = (cur_q.step >= K_VCC);
                    nxt_d.io_on  = (cur_q.step >= K_IO);
                    nxt_d.clk_on = 1'b0;
                    if (fault_now) begin
                        nxt_d.fault_n = 1'b0;
                        nxt_d.removed = !present_s;
                    end
                end else if (tick) begin
                    if (cur_q.step == K_ONM1) begin
                        nxt_d.state = ST_ON;
                        nxt_d.step  = '0;
                    end else begin
                        nxt_d.step = cur_q.step + 1'b1;
                    end
                end
            end
            ST_ON: begin
                if (go_down) begin
                    nxt_d.state  = ST_DOWN;
                    nxt_d.step   = '0;
                    nxt_d.vcc_on = 1'b1;
                    nxt_d.io_on  = 1'b1;
                    nxt_d.clk_on = 1'b1;
                    if (fault_now) begin
                        nxt_d.fault_n = 1'b0;
                        nxt_d.removed = !present_s;
                    end
                end
            end
            ST_DOWN: begin
                if (tick) begin
                    if (cur_q.step == K_OFFM1) begin
                        nxt_d.state   = ST_IDLE;
                        nxt_d.step    = '0;
                        nxt_d.vcc_on  = 1'b0;
                        nxt_d.io_on   = 1'b0;
                        nxt_d.clk_on  = 1'b0;
                        nxt_d.fault_n = !cur_q.removed;
                    end else begin
                        nxt_d.step = cur_q.step + 1'b1;
                    end
                end
            end
            default: nxt_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SEQ_RST;
        else        cur_q <= nxt_d;
    end

    // Contact decode from registered state
    logic in_up, in_on, in_down, window, clk_free;

    assign in_up    = (cur_q.state == ST_UP);
    assign in_on    = (cur_q.state == ST_ON);
    assign in_down  = (cur_q.state == ST_DOWN);
    assign window   = in_up && (cur_q.step >= K_IO);
    assign clk_free = in_on || (in_down && cur_q.clk_on && (cur_q.step < K_CLKOFF));

    assign restart  = (nxt_d.state != cur_q.state);
    assign conv_en  = (cur_q.state != ST_IDLE);
    assign vcc_en   = (in_up && (cur_q.step >= K_VCC)) || in_on
                    || (in_down && cur_q.vcc_on && (cur_q.step < K_VCCOFF));
    assign clamp_en = (cur_q.state == ST_IDLE) || (in_up && (cur_q.step < K_VCC))
                    || (in_down && !cur_q.vcc_on);
    assign io_en    = window || in_on
                    || (in_down && cur_q.io_on && (cur_q.step < K_IOOFF));
    assign card_clk = window ? (clk_src & rst_in) : (clk_free & clk_src);
    assign card_rst = in_on & ~rst_in;
    assign fault_n  = cur_q.fault_n;
endmodule

// File: rtl/card_power_sequencer.sv
module card_power_sequencer #(
    parameter int TICK_DIV    = 64,
    parameter int SYNC_STAGES = 2,
    parameter int VCC_STEP    = 2,
    parameter int IO_STEP     = 4,
    parameter int RST_STEP    = 7,
    parameter int CLKOFF_STEP = 1,
    parameter int IOOFF_STEP  = 1,
    parameter int VCCOFF_STEP = 2,
    parameter int OFF_STEP    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    input  logic card_present,
    input  logic supply_alarm,
    input  logic overcurrent,
    input  logic rst_in,
    input  logic clk_src,
    output logic conv_en,
    output logic vcc_en,
    output logic clamp_en,
    output logic io_en,
    output logic card_clk,
    output logic card_rst,
    output logic fault_n
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic present_s, alarm_s, ovc_s;
    logic tick, restart;

    assign raw_in = {overcurrent, supply_alarm, card_present};
    assign present_s = sync_out[0];
    assign alarm_s   = sync_out[1];
    assign ovc_s     = sync_out[2];

    cardseq_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    cardseq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    cardseq_fsm #(
        .VCC_STEP    (VCC_STEP),
        .IO_STEP     (IO_STEP),
        .RST_STEP    (RST_STEP),
        .CLKOFF_STEP (CLKOFF_STEP),
        .IOOFF_STEP  (IOOFF_STEP),
        .VCCOFF_STEP (VCCOFF_STEP),
        .OFF_STEP    (OFF_STEP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_n   (start_n),
        .present_s (present_s),
        .alarm_s   (alarm_s),
        .ovc_s     (ovc_s),
        .rst_in    (rst_in),
        .clk_src   (clk_src),
        .restart   (restart),
        .conv_en   (conv_en),
        .vcc_en    (vcc_en),
        .clamp_en  (clamp_en),
        .io_en     (io_en),
        .card_clk  (card_clk),
        .card_rst  (card_rst),
        .fault_n   (fault_n)
    );
endmodule

// File: rtl/cardseq_chk.sv
module cardseq_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_en,
    input logic vcc_en,
    input logic clamp_en,
    input logic io_en,
    input logic card_clk,
    input logic card_rst,
    input logic fault_n,
    input logic present_s,
    input logic alarm_s
);
    // R1: clamp engaged means every contact is low
    p_clamp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> (!vcc_en && !io_en && !card_clk && !card_rst));

    // R2: a session only begins from a good, present card
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_en) |-> ($past(present_s) && !$past(alarm_s)));

    // R3: supply never on without the converter
    p_vcc_needs_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_en |-> conv_en);

    // R4: I/O never enabled without supply
    p_io_needs_vcc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> vcc_en);

    // R6: reset contact only driven with I/O and supply up
    p_rst_needs_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (io_en && vcc_en));

    // R9: fault line only releases once the contacts are down
    p_fault_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> !conv_en);
endmodule

bind card_power_sequencer cardseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_en   (conv_en),
    .vcc_en    (vcc_en),
    .clamp_en  (clamp_en),
    .io_en     (io_en),
    .card_clk  (card_clk),
    .card_rst  (card_rst),
    .fault_n   (fault_n),
    .present_s (present_s),
    .alarm_s   (alarm_s)
);

// File: tb/tb_card_power_sequencer.sv
`timescale 1ns/1ps
module tb_card_power_sequencer;
    localparam int TD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1;
    logic card_present = 1'b1;
    logic supply_alarm = 1'b0;
    logic overcurrent = 1'b0;
    logic rst_in = 1'b0;
    logic clk_src = 1'b1;
    logic conv_en, vcc_en, clamp_en, io_en, card_clk, card_rst, fault_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_power_sequencer #(.TICK_DIV(TD)) dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n),
        .card_present(card_present), .supply_alarm(supply_alarm),
        .overcurrent(overcurrent), .rst_in(rst_in), .clk_src(clk_src),
        .conv_en(conv_en), .vcc_en(vcc_en), .clamp_en(clamp_en),
        .io_en(io_en), .card_clk(card_clk), .card_rst(card_rst),
        .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 conv_en", conv_en, 0);
        chk("R1 vcc_en", vcc_en, 0);
        chk("R1 io_en", io_en, 0);
        chk("R1 card_clk", card_clk, 0);
        chk("R1 card_rst", card_rst, 0);
        chk("R1 clamp_en", clamp_en, 1);
        chk("R1 fault_n", fault_n, 1);
    endtask

    task automatic t_powerup;
        rst_in = 1'b0; clk_src = 1'b1;
        start_n = 1'b0;
        edges(1);
        chk("R3 conv at accept", conv_en, 1);
        chk("R3 vcc step0", vcc_en, 0);
        chk("R3 clamp step0", clamp_en, 1);
        edges(2*TD-1);
        chk("R3 vcc before tick2", vcc_en, 0);
        edges(1);
        chk("R3 vcc at tick2", vcc_en, 1);
        chk("R3 clamp released", clamp_en, 0);
        chk("R4 io before tick4", io_en, 0);
        edges(2*TD-2);
        rst_in = 1'b1; #1;
        chk("R5 clock held before window", card_clk, 0);
        edges(1);
        chk("R4 io still off", io_en, 0);
        edges(1);
        chk("R4 io at tick4", io_en, 1);
        chk("R5 clock gated on", card_clk, 1);
        chk("R5 rst low in window", card_rst, 0);
        rst_in = 1'b0; #1;
        chk("R5 clock gated off", card_clk, 0);
        edges(3*TD-1);
        chk("R5 rst low at window end", card_rst, 0);
        edges(1);
        chk("R6 rst is not rst_in", card_rst, 1);
        chk("R6 clock free", card_clk, 1);
        rst_in = 1'b1; #1;
        chk("R6 rst follows rst_in", card_rst, 0);
        chk("R6 clock ignores rst_in", card_clk, 1);
        rst_in = 1'b0;
    endtask

    task automatic t_host_down;
        @(negedge clk);
        start_n = 1'b1;
        edges(1);
        chk("R7 rst drops first", card_rst, 0);
        chk("R7 clock runs step0", card_clk, 1);
        chk("R7 io step0", io_en, 1);
        edges(TD-1);
        chk("R7 io before tick1", io_en, 1);
        edges(1);
        chk("R7 clock stopped", card_clk, 0);
        chk("R7 io released", io_en, 0);
        chk("R7 vcc still on", vcc_en, 1);
        edges(TD);
        chk("R7 vcc off", vcc_en, 0);
        edges(3*TD-1);
        chk("R7 conv before tick5", conv_en, 1);
        chk("R7 clamp before tick5", clamp_en, 0);
        edges(1);
        chk("R7 conv off", conv_en, 0);
        chk("R7 clamp on", clamp_en, 1);
        chk("R7 fault_n untouched", fault_n, 1);
    endtask

    task automatic up_quick;
        start_n = 1'b0;
        edges(7*TD + 2);
    endtask

    task automatic t_refuse;
        supply_alarm = 1'b1;
        edges(3);
        start_n = 1'b0;
        edges(10);
        chk("R2 refused under alarm", conv_en, 0);
        supply_alarm = 1'b0;
        edges(10);
        chk("R2 held low no start", conv_en, 0);
        start_n = 1'b1;
        card_present = 1'b0;
        edges(3);
        start_n = 1'b0;
        edges(10);
        chk("R2 refused without card", conv_en, 0);
        chk("R2 idle absence no fault", fault_n, 1);
        start_n = 1'b1;
        card_present = 1'b1;
        edges(3);
    endtask

    task automatic t_ignore_start;
        up_quick();
        start_n = 1'b1;
        edges(TD);
        start_n = 1'b0;
        edges(5*TD + 10);
        chk("R11 start in shutdown ignored", conv_en, 0);
        start_n = 1'b1;
        edges(2);
    endtask

    task automatic t_removal;
        up_quick();
        card_present = 1'b0;
        edges(2);
        chk("R8 removal not yet seen", fault_n, 1);
        edges(1);
        chk("R8 removal fault", fault_n, 0);
        chk("R8 rst dropped", card_rst, 0);
        edges(5*TD);
        chk("R8 removal shutdown done", conv_en, 0);
        chk("R9 fault kept after removal", fault_n, 0);
        start_n = 1'b1;
        edges(5);
        chk("R9 fault still kept", fault_n, 0);
        card_present = 1'b1;
        edges(2);
        chk("R9 insert not yet seen", fault_n, 0);
        edges(1);
        chk("R9 released on insert", fault_n, 1);
    endtask

    task automatic t_alarm;
        up_quick();
        supply_alarm = 1'b1;
        edges(3);
        chk("R8 alarm fault", fault_n, 0);
        supply_alarm = 1'b0;
        edges(5*TD - 1);
        chk("R9 fault low during shutdown", fault_n, 0);
        edges(1);
        chk("R9 alarm fault released", fault_n, 1);
        chk("R9 idle", conv_en, 0);
        start_n = 1'b1;
        edges(2);
    endtask

    task automatic t_up_fault;
        int bad;
        bad = 0;
        start_n = 1'b0;
        edges(1);
        overcurrent = 1'b1;
        edges(3);
        chk("R10 fault in power-up", fault_n, 0);
        chk("R10 converter held", conv_en, 1);
        for (int i = 0; i < 5*TD - 1; i++) begin
            if (vcc_en !== 1'b0 || io_en !== 1'b0 || clamp_en !== 1'b1) bad++;
            edges(1);
        end
        chk("R10 unused outputs stay off", bad, 0);
        edges(1);
        chk("R10 idle after shutdown", conv_en, 0);
        chk("R10 fault released", fault_n, 1);
        overcurrent = 1'b0;
        start_n = 1'b1;
        edges(3);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        edges(3);
        t_reset();
        rst_n = 1'b1;
        edges(4);
        t_reset();
        t_refuse();
        t_powerup();
        t_host_down();
        edges(3);
        t_ignore_start();
        t_removal();
        edges(3);
        t_alarm();
        t_up_fault();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule